// File: doc/BRIEF.md
# Tune-Then-Replace Repair Controller

This controller looks after one function that is built from several redundant sub-blocks, each with a small set of digital trim settings. It asks an outside estimator for a test-mode measurement, receives a time-before-failure figure, and decides what repair is needed. A figure at or below a programmable limit first steps the trim code of the sub-block in use. Once every trim code of that sub-block is spent, it moves the one-hot select to the next spare and starts again from trim zero.

The time of the next test is not fixed. Each accepted estimate is scaled by a design-time constant, given a programmable lower bound, and added to the present time. Every accepted measurement is also sent out for storage with its timestamp. When the last spare has no trim codes left and still needs repair, a sticky alarm is raised and the repair outputs freeze until reset.

Top module: `tune_replace_ctrl`

## Requirements
- R1: A synchronous reset, while held and right after release, gives test_req=1, trim_code=000, blk_sel=001, next_test=0, exhausted=0 and log_valid=0. The first test is then waiting.
- R2: In the initial test, a measurement whose estimate is above tbf_limit is accepted. test_req is 0 in the next cycle and the trim code and select do not change.
- R3: On an accepted measurement that does not lead to a switchover or the alarm, next_test becomes now_time + max((meas_tbf*667)>>10, min_gap) in the next cycle.
- R4: An accepted estimate less than or equal to tbf_limit, with trim_code below 111, raises trim_code by one. In the same cycle it reschedules as in R3.
- R5: In normal operation test_req stays 0 while now_time < next_test. It goes to 1 on the cycle after now_time >= next_test.
- R6: In the cycle after any accepted measurement, log_valid=1, log_stamp holds the now_time of the measurement cycle and log_tbf holds its estimate. In all other cycles log_valid=0.
- R7: A repair request with trim_code=111 on a sub-block that is not the last moves blk_sel one bit up (001, then 010, then 100) and sets trim_code to 000. next_test does not change. test_req stays 1 for one extra cycle, and a measurement offered during that extra cycle is ignored.
- R8: blk_sel is always one-hot.
- R9: A repair request with trim_code=111 on the last sub-block sets exhausted=1 and test_req=0. From then on trim_code, blk_sel and next_test no longer change and measurements are ignored, until reset.
- R10: A measurement offered while test_req=0 is ignored: no change to trim_code or blk_sel, and log_valid stays 0.
- R11: Reset clears the alarm and brings back the state described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| now_time | input | TIME_W | Present time count |
| meas_valid | input | 1 | Estimator result is valid this cycle |
| meas_tbf | input | TBF_W | Estimated time before failure |
| tbf_limit | input | TBF_W | Repair threshold (repair when estimate <= limit) |
| min_gap | input | TIME_W | Lower bound on the next-test interval |
| test_req | output | 1 | Test-mode request |
| trim_code | output | TRIM_W | Trim code of the active sub-block |
| blk_sel | output | NUM_BLK | One-hot active sub-block select |
| next_test | output | TIME_W | Scheduled time of the next test |
| exhausted | output | 1 | Sticky alarm: no repair left |
| log_valid | output | 1 | Measurement record valid |
| log_stamp | output | TIME_W | Timestamp of the recorded measurement |
| log_tbf | output | TBF_W | Recorded estimate |

## Verification
One accepted measurement can both repair and reschedule. A trim step and a new next_test time are produced from the same estimate on the same edge. The bench walks a table of estimates that fall above, equal to and below the limit, including estimates small enough to hit the min_gap floor. After each one it checks the trim code and next_test in the same sampling cycle against values it computes itself. It also checks that a switchover leaves next_test unchanged while it steps the select. Finally, it offers a measurement during the switchover hold cycle and checks that the measurement is ignored.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [2:0] {
      RR_INIT = 3'd0,
      RR_RUN  = 3'd1,
      RR_TEST = 3'd2,
      RR_HOLD = 3'd3,
      RR_DEAD = 3'd4
   } rr_state_e;

endpackage

// File: rtl/rr_sched.sv
module rr_sched #(
   parameter int TBF_W       = 16,
   parameter int TIME_W      = 32,
   parameter int SCALE_NUM   = 667,
   parameter int SCALE_SHIFT = 10
) (
   input  logic [TBF_W-1:0]  tbf,
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] floor_gap,
   output logic [TIME_W-1:0] due
);
   localparam int K_W    = $clog2(SCALE_NUM + 1);
   localparam int PROD_W = TBF_W + K_W;

   initial begin : p_param_chk
      assert (SCALE_NUM >= 1) else $fatal(1, "SCALE_NUM must be positive");
      assert (TIME_W >= PROD_W) else $fatal(1, "TIME_W too narrow for scaled estimate");
      assert (SCALE_SHIFT < PROD_W) else $fatal(1, "SCALE_SHIFT too large");
   end

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;
   logic [TIME_W-1:0] span;
   logic [TIME_W-1:0] gap;

   generate
      if (SCALE_NUM == 1) begin : g_unit
         assign prod = PROD_W'(tbf);
      end else begin : g_mult
         assign prod = PROD_W'(tbf) * PROD_W'(SCALE_NUM);
      end
      if (SCALE_SHIFT == 0) begin : g_noshift
         assign scaled = prod;
      end else begin : g_shift
         assign scaled = prod >> SCALE_SHIFT;
      end
   endgenerate

   always_comb begin
      span = TIME_W'(scaled);
      gap  = (span < floor_gap) ? floor_gap : span;
      due  = now + gap;
   end

endmodule

// File: rtl/rr_trim_sel.sv
module rr_trim_sel #(
   parameter int NUM_BLK = 3,
   parameter int TRIM_W  = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               adv_trim,
   input  logic               adv_blk,
   output logic [TRIM_W-1:0]  trim,
   output logic [NUM_BLK-1:0] sel,
   output logic               trim_full,
   output logic               last_blk
);
   localparam logic [TRIM_W-1:0]  TRIM_TOP  = '1;
   localparam logic [NUM_BLK-1:0] SEL_FIRST = NUM_BLK'(1);

   initial begin : p_param_chk
      assert (NUM_BLK >= 2) else $fatal(1, "NUM_BLK must be at least 2");
      assert (TRIM_W >= 1) else $fatal(1, "TRIM_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trim <= '0;
         sel  <= SEL_FIRST;
      end else if (adv_blk) begin
         trim <= '0;
         sel  <= {sel[NUM_BLK-2:0], 1'b0};
      end else if (adv_trim) begin
         trim <= trim + TRIM_W'(1);
      end
   end

   assign trim_full = (trim == TRIM_TOP);
   assign last_blk  = sel[NUM_BLK-1];

   // R8: select register never holds zero or several bits
   a_r8_sel_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot(sel));

   // R4: a trim step moves the code up by exactly one
   a_r4_trim_step: assert property (@(posedge clk) disable iff (rst)
      (adv_trim && !adv_blk) |=> (trim == $past(trim) + TRIM_W'(1)));

   // R7: switchover restarts trim and moves the select one place
   a_r7_swap_restart: assert property (@(posedge clk) disable iff (rst)
      adv_blk |=> (trim == '0) && (sel == {$past(sel[NUM_BLK-2:0]), 1'b0}));

endmodule

// File: rtl/tune_replace_ctrl.sv
module tune_replace_ctrl #(
   parameter int NUM_BLK     = 3,
   parameter int TRIM_W      = 3,
   parameter int TIME_W      = 32,
   parameter int TBF_W       = 16,
   parameter int SCALE_NUM   = 667,
   parameter int SCALE_SHIFT = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [TIME_W-1:0]  now_time,
   input  logic               meas_valid,
   input  logic [TBF_W-1:0]   meas_tbf,
   input  logic [TBF_W-1:0]   tbf_limit,
   input  logic [TIME_W-1:0]  min_gap,
   output logic               test_req,
   output logic [TRIM_W-1:0]  trim_code,
   output logic [NUM_BLK-1:0] blk_sel,
   output logic [TIME_W-1:0]  next_test,
   output logic               exhausted,
   output logic               log_valid,
   output logic [TIME_W-1:0]  log_stamp,
   output logic [TBF_W-1:0]   log_tbf
);
   import rr_pkg::*;

   rr_state_e         state, state_nx;
   logic              accept, need_fix, adv_trim, adv_blk, go_dead, load_sched, due_now;
   logic              trim_full, last_blk;
   logic [TIME_W-1:0] sched_due;

   rr_sched #(
      .TBF_W(TBF_W), .TIME_W(TIME_W),
      .SCALE_NUM(SCALE_NUM), .SCALE_SHIFT(SCALE_SHIFT)
   ) u_sched (
      .tbf(meas_tbf), .now(now_time), .floor_gap(min_gap), .due(sched_due)
   );

   rr_trim_sel #(.NUM_BLK(NUM_BLK), .TRIM_W(TRIM_W)) u_trim_sel (
      .clk(clk), .rst(rst), .adv_trim(adv_trim), .adv_blk(adv_blk),
      .trim(trim_code), .sel(blk_sel), .trim_full(trim_full), .last_blk(last_blk)
   );

   always_comb begin
      accept     = meas_valid && ((state == RR_INIT) || (state == RR_TEST));
      need_fix   = accept && (meas_tbf <= tbf_limit);
      adv_trim   = need_fix && !trim_full;
      adv_blk    = need_fix && trim_full && !last_blk;
      go_dead    = need_fix && trim_full && last_blk;
      load_sched = accept && !adv_blk && !go_dead;
      due_now    = (now_time >= next_test);
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         RR_INIT, RR_TEST: begin
            if (accept) begin
               if (go_dead)      state_nx = RR_DEAD;
               else if (adv_blk) state_nx = RR_HOLD;
               else              state_nx = RR_RUN;
            end
         end
         RR_RUN:  if (due_now) state_nx = RR_TEST;
         RR_HOLD: state_nx = RR_TEST;
         RR_DEAD: state_nx = RR_DEAD;
         default: state_nx = RR_INIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= RR_INIT;
         next_test <= '0;
         log_valid <= 1'b0;
         log_stamp <= '0;
         log_tbf   <= '0;
      end else begin
         state     <= state_nx;
         log_valid <= accept;
         if (load_sched) next_test <= sched_due;
         if (accept) begin
            log_stamp <= now_time;
            log_tbf   <= meas_tbf;
         end
      end
   end

   assign test_req  = (state == RR_INIT) || (state == RR_TEST) || (state == RR_HOLD);
   assign exhausted = (state == RR_DEAD);

   // R9: alarm is sticky and freezes the repair outputs
   a_r9_dead_frozen: assert property (@(posedge clk) disable iff (rst)
      exhausted |=> exhausted && $stable(trim_code) && $stable(blk_sel) && $stable(next_test));

   // R7: test mode spans the hold cycle and the following test cycle
   a_r7_hold_test: assert property (@(posedge clk) disable iff (rst)
      adv_blk |=> test_req ##1 test_req);

   // R10: offers outside test mode leave trim and select alone
   a_r10_idle_ignore: assert property (@(posedge clk) disable iff (rst)
      (!test_req && meas_valid) |=> $stable(trim_code) && $stable(blk_sel));

   // R6: a record follows every accepted measurement
   a_r6_log_pulse: assert property (@(posedge clk) disable iff (rst)
      accept |=> log_valid && (log_tbf == $past(meas_tbf)));

   // R7: switchover keeps the schedule
   a_r7_sched_kept: assert property (@(posedge clk) disable iff (rst)
      adv_blk |=> $stable(next_test));

endmodule

// File: tb/tune_replace_ctrl_bench.sv
module tune_replace_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int LIMIT = 100;
   localparam int GAP   = 50;

   // {estimate[31:16], expected trim[15:8], expected select[7:0]}
   localparam logic [31:0] VEC [0:11] = '{
      {16'd5000, 8'd0, 8'd1},
      {16'd100,  8'd1, 8'd1},
      {16'd20,   8'd2, 8'd1},
      {16'd300,  8'd2, 8'd1},
      {16'd99,   8'd3, 8'd1},
      {16'd0,    8'd4, 8'd1},
      {16'd1,    8'd5, 8'd1},
      {16'd77,   8'd6, 8'd1},
      {16'd101,  8'd6, 8'd1},
      {16'd7,    8'd7, 8'd1},
      {16'd8,    8'd0, 8'd2},
      {16'd2000, 8'd0, 8'd2}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] now_time = '0;
   logic        meas_valid = 1'b0;
   logic [15:0] meas_tbf = '0;
   logic [15:0] tbf_limit = 16'(LIMIT);
   logic [31:0] min_gap = 32'(GAP);
   logic        test_req, exhausted, log_valid;
   logic [2:0]  trim_code;
   logic [2:0]  blk_sel;
   logic [31:0] next_test, log_stamp;
   logic [15:0] log_tbf;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_next = '0;
   bit done = 1'b0;

   tune_replace_ctrl u_tune_replace_ctrl (
      .clk(clk), .rst(rst), .now_time(now_time), .meas_valid(meas_valid),
      .meas_tbf(meas_tbf), .tbf_limit(tbf_limit), .min_gap(min_gap),
      .test_req(test_req), .trim_code(trim_code), .blk_sel(blk_sel),
      .next_test(next_test), .exhausted(exhausted), .log_valid(log_valid),
      .log_stamp(log_stamp), .log_tbf(log_tbf)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [31:0] gap_of(input int tbf);
      logic [31:0] g;
      g = 32'((tbf * 667) >> 10);
      if (g < 32'(GAP)) g = 32'(GAP);
      return g;
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ensure_test();
      if (test_req !== 1'b1) begin
         now_time = exp_next;
         tick();
      end
      tick();
   endtask

   task automatic measure(input int tbf);
      meas_valid = 1'b1;
      meas_tbf   = 16'(tbf);
      tick();
      meas_valid = 1'b0;
   endtask

   task automatic repair_round(input int tbf, input int exp_trim);
      logic [31:0] t;
      ensure_test();
      t = now_time;
      measure(tbf);
      exp_next = t + gap_of(tbf);
      check("R4", "trim step", 64'(trim_code), 64'(exp_trim));
      check("R3", "schedule", 64'(next_test), 64'(exp_next));
   endtask

   initial begin : watchdog
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] prev_sel;
      logic [31:0] t;
      logic [31:0] keep;
      @(negedge clk);
      tick();
      check("R1", "test_req in reset", 64'(test_req), 64'd1);
      tick();
      rst = 1'b0;
      check("R1", "trim", 64'(trim_code), 64'd0);
      check("R1", "select", 64'(blk_sel), 64'd1);
      check("R1", "next_test", 64'(next_test), 64'd0);
      check("R1", "alarm", 64'(exhausted), 64'd0);
      check("R1", "log_valid", 64'(log_valid), 64'd0);
      check("R1", "test_req", 64'(test_req), 64'd1);

      now_time = 32'd1000;
      prev_sel = 8'd1;
      for (int i = 0; i < 12; i++) begin
         int  tbf;
         bit  swap;
         tbf  = int'(VEC[i][31:16]);
         swap = (VEC[i][7:0] != prev_sel);
         ensure_test();
         t = now_time;
         measure(tbf);
         check("R4", $sformatf("vec %0d trim", i), 64'(trim_code), 64'(VEC[i][15:8]));
         check("R7", $sformatf("vec %0d select", i), 64'(blk_sel), 64'(VEC[i][7:0]));
         check("R8", $sformatf("vec %0d onehot", i), 64'($countones(blk_sel)), 64'd1);
         check("R6", $sformatf("vec %0d log", i), {31'd0, log_valid, log_stamp}, {31'd0, 1'b1, t});
         check("R6", $sformatf("vec %0d log value", i), 64'(log_tbf), 64'(tbf));
         if (swap) begin
            check("R7", $sformatf("vec %0d hold test", i), 64'(test_req), 64'd1);
            check("R7", $sformatf("vec %0d schedule kept", i), 64'(next_test), 64'(exp_next));
         end else begin
            exp_next = t + gap_of(tbf);
            check("R2", $sformatf("vec %0d test ends", i), 64'(test_req), 64'd0);
            check("R3", $sformatf("vec %0d schedule", i), 64'(next_test), 64'(exp_next));
         end
         prev_sel = VEC[i][7:0];
      end

      // R10 and R5: before the due time, offers are ignored
      now_time = exp_next - 32'd1;
      tick();
      check("R5", "not yet due", 64'(test_req), 64'd0);
      measure(0);
      check("R10", "trim unchanged", 64'(trim_code), 64'd0);
      check("R10", "no record", 64'(log_valid), 64'd0);
      check("R10", "still idle", 64'(test_req), 64'd0);
      now_time = exp_next;
      tick();
      check("R5", "due at equality", 64'(test_req), 64'd1);

      for (int k = 1; k <= 7; k++) repair_round(3, k);

      // R7: switchover to last block, offer in hold cycle ignored
      ensure_test();
      keep = next_test;
      measure(3);
      check("R7", "swap select", 64'(blk_sel), 64'd4);
      check("R7", "swap trim", 64'(trim_code), 64'd0);
      check("R7", "swap schedule kept", 64'(next_test), 64'(keep));
      measure(1);
      check("R7", "hold offer ignored trim", 64'(trim_code), 64'd0);
      check("R7", "hold offer no record", 64'(log_valid), 64'd0);
      check("R7", "hold test_req", 64'(test_req), 64'd1);
      t = now_time;
      measure(4000);
      exp_next = t + gap_of(4000);
      check("R2", "new block accepted", 64'(test_req), 64'd0);
      check("R3", "new block schedule", 64'(next_test), 64'(exp_next));

      for (int k = 1; k <= 7; k++) repair_round(0, k);

      // R9: last block exhausted
      ensure_test();
      keep = next_test;
      measure(0);
      check("R9", "alarm", 64'(exhausted), 64'd1);
      check("R9", "test_req low", 64'(test_req), 64'd0);
      check("R9", "trim frozen", 64'(trim_code), 64'd7);
      check("R9", "select frozen", 64'(blk_sel), 64'd4);
      now_time = 32'hFFFF_0000;
      measure(0);
      measure(0);
      tick();
      check("R9", "still alarmed", 64'(exhausted), 64'd1);
      check("R9", "schedule frozen", 64'(next_test), 64'(keep));
      check("R9", "no test", 64'(test_req), 64'd0);
      check("R9", "no record", 64'(log_valid), 64'd0);

      // R11: reset clears the alarm
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check("R11", "alarm cleared", 64'(exhausted), 64'd0);
      check("R11", "trim", 64'(trim_code), 64'd0);
      check("R11", "select", 64'(blk_sel), 64'd1);
      check("R11", "test pending", 64'(test_req), 64'd1);
      check("R11", "schedule", 64'(next_test), 64'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule